// File: doc/BRIEF.md
# Parallel Match Length Comparator

This block is the comparison stage of a dictionary-based compressor that looks at several byte positions per clock. At each of `VEC` positions it holds a current substring of `VEC` bytes and `VEC` candidate windows read from history, one per history bank. Each candidate comes with a usable flag and a back-distance (offset). The block counts the leading bytes that each candidate shares with its substring. It then reduces the counts per position to the longest one and reports that length together with the winning candidate's offset.

All `VEC×VEC` comparisons and the per-position reductions are combinational and unrolled. A single register stage holds the result. Every position is handled on its own: the block does not choose between positions, and it does not discard short or overlapping matches. That work belongs to the stage that follows.

Byte `b` of position `p` sits at `cur_win[(p*VEC+b)*8 +: 8]`, with byte 0 being the first byte of the substring. Candidate `c` of position `p` uses three fields:

- its bytes at `cand_data[((p*VEC+c)*VEC+b)*8 +: 8]`
- its flag at `cand_ok[p*VEC+c]`
- its offset at `cand_off[(p*VEC+c)*OFFW +: OFFW]`

The result for position `p` is at `best_len[p*LENW +: LENW]` and `best_off[p*OFFW +: OFFW]`.

Top module: `match_len_cmp`

## Requirements
- R1: A candidate's length is the number of consecutive equal bytes counted from byte 0, from 0 up to VEC. Bytes after the first mismatch do not count even when they are equal.
- R2: For each position the reported length is the largest of its VEC candidate lengths.
- R3: When several candidates share the largest length, the one with the lowest bank index `c` wins, and its offset is reported.
- R4: A candidate whose `cand_ok` bit is 0 counts as length 0.
- R5: A candidate whose offset is 0 counts as length 0.
- R6: A candidate whose offset exceeds MAX_OFF (default 262144) counts as length 0. An offset equal to MAX_OFF is usable.
- R7: When the reported length of a position is 0, its reported offset is 0. A nonzero length always carries an offset in 1..MAX_OFF.
- R8: `out_valid` equals `in_valid` of the previous clock. Results for inputs presented with `in_valid` high appear on the outputs after that one clock edge.
- R9: While `in_valid` is low, `best_len` and `best_off` keep their values whatever the other inputs do.
- R10: After reset, `out_valid`, every `best_len` and every `best_off` are 0.
- R11: Each position's result depends only on that position's substring and candidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Inputs carry a new set of substrings and candidates |
| cur_win | input | VEC*VEC*8 | Current substrings, one per position |
| cand_data | input | VEC*VEC*VEC*8 | Candidate windows, VEC per position |
| cand_ok | input | VEC*VEC | Usable flag per candidate |
| cand_off | input | VEC*VEC*OFFW | Back-distance per candidate |
| out_valid | output | 1 | Registered copy of in_valid |
| best_len | output | VEC*LENW | Best length per position |
| best_off | output | VEC*OFFW | Offset of the winning candidate per position |

## Verification
The main sweep places the first mismatching byte of each of the four candidates at every index from 0 to VEC, covering all 625 combinations. Bytes after the mismatch are kept equal, so a count that fails to stop at the first difference shows up. The sweep gives each position a different combination and a different mix of flags and edge offsets (0, 1, 2047, MAX_OFF, MAX_OFF+1). This separates the gating of a candidate from its count, and each position's result from its neighbours'. Directed patterns cover the remaining cases:

- equal lengths in several banks, to pin the lowest-bank tie rule
- the all-invalid case, which must give offset 0
- input changes while `in_valid` is low, which must leave the outputs unchanged

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  localparam int BYTE_W      = 8;
  localparam int DEF_VEC     = 16;
  localparam int DEF_MAX_OFF = 262144;
endpackage

// File: rtl/mlc_pair_len.sv
module mlc_pair_len #(
  parameter int VEC     = 16,
  parameter int MAX_OFF = 262144,
  parameter int LENW    = 5,
  parameter int OFFW    = 19
) (
  input  logic [VEC*mlc_pkg::BYTE_W-1:0] cur,
  input  logic [VEC*mlc_pkg::BYTE_W-1:0] cand,
  input  logic                           ok,
  input  logic [OFFW-1:0]                off,
  output logic [LENW-1:0]                len
);
  localparam int BW = mlc_pkg::BYTE_W;

  logic [VEC-1:0] eq;
  logic           usable;

  genvar b;
  generate
    for (b = 0; b < VEC; b++) begin : g_byte
      assign eq[b] = (cur[b*BW +: BW] == cand[b*BW +: BW]);
    end
  endgenerate

  assign usable = ok && (off != '0) && (off <= OFFW'(MAX_OFF));

  always_comb begin
    logic run;
    run = 1'b1;
    len = '0;
    for (int i = 0; i < VEC; i++) begin
      if (run && eq[i]) len = len + LENW'(1);
      else              run = 1'b0;
    end
    if (!usable) len = '0;
  end
endmodule

// File: rtl/mlc_best_pick.sv
module mlc_best_pick #(
  parameter int VEC  = 16,
  parameter int LENW = 5,
  parameter int OFFW = 19
) (
  input  logic [VEC*LENW-1:0] lens,
  input  logic [VEC*OFFW-1:0] offs,
  output logic [LENW-1:0]     len,
  output logic [OFFW-1:0]     off
);
  always_comb begin
    len = lens[0 +: LENW];
    off = offs[0 +: OFFW];
    for (int c = 1; c < VEC; c++) begin
      // strictly greater: an earlier bank keeps a tie
      if (lens[c*LENW +: LENW] > len) begin
        len = lens[c*LENW +: LENW];
        off = offs[c*OFFW +: OFFW];
      end
    end
    if (len == '0) off = '0;
  end
endmodule

// File: rtl/match_len_cmp.sv
module match_len_cmp #(
  parameter  int VEC     = mlc_pkg::DEF_VEC,
  parameter  int MAX_OFF = mlc_pkg::DEF_MAX_OFF,
  localparam int LENW    = $clog2(VEC + 1),
  localparam int OFFW    = $clog2(MAX_OFF + 1),
  localparam int BW      = mlc_pkg::BYTE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [VEC*VEC*BW-1:0]     cur_win,
  input  logic [VEC*VEC*VEC*BW-1:0] cand_data,
  input  logic [VEC*VEC-1:0]        cand_ok,
  input  logic [VEC*VEC*OFFW-1:0]   cand_off,
  output logic                      out_valid,
  output logic [VEC*LENW-1:0]       best_len,
  output logic [VEC*OFFW-1:0]       best_off
);
  localparam int SUBW = VEC * BW;

  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [VEC*VEC*LENW-1:0] pair_len;
  logic [VEC*LENW-1:0]     pick_len;
  logic [VEC*OFFW-1:0]     pick_off;

  genvar p, c;
  generate
    for (p = 0; p < VEC; p++) begin : g_pos
      for (c = 0; c < VEC; c++) begin : g_cand
        mlc_pair_len #(.VEC(VEC), .MAX_OFF(MAX_OFF), .LENW(LENW), .OFFW(OFFW)) u_pair (
          .cur  (cur_win[p*SUBW +: SUBW]),
          .cand (cand_data[(p*VEC+c)*SUBW +: SUBW]),
          .ok   (cand_ok[p*VEC+c]),
          .off  (cand_off[(p*VEC+c)*OFFW +: OFFW]),
          .len  (pair_len[(p*VEC+c)*LENW +: LENW])
        );
      end
      mlc_best_pick #(.VEC(VEC), .LENW(LENW), .OFFW(OFFW)) u_pick (
        .lens (pair_len[p*VEC*LENW +: VEC*LENW]),
        .offs (cand_off[p*VEC*OFFW +: VEC*OFFW]),
        .len  (pick_len[p*LENW +: LENW]),
        .off  (pick_off[p*OFFW +: OFFW])
      );

      AST_ZERO_LEN_NO_OFF: assert property (@(posedge clk) disable iff (!rst_q)
        (best_len[p*LENW +: LENW] == '0) |-> (best_off[p*OFFW +: OFFW] == '0)); // R7
      AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_q)
        best_len[p*LENW +: LENW] <= LENW'(VEC)); // R1
      AST_OFF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_q)
        (best_len[p*LENW +: LENW] != '0) |->
        (best_off[p*OFFW +: OFFW] != '0 && best_off[p*OFFW +: OFFW] <= OFFW'(MAX_OFF))); // R6
    end
  endgenerate

  logic                vld_d;
  logic [VEC*LENW-1:0] len_d;
  logic [VEC*OFFW-1:0] off_d;

  always_comb begin
    vld_d = in_valid;
    len_d = best_len;
    off_d = best_off;
    if (in_valid) begin
      len_d = pick_len;
      off_d = pick_off;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid <= 1'b0;
      best_len  <= '0;
      best_off  <= '0;
    end else begin
      out_valid <= vld_d;
      best_len  <= len_d;
      best_off  <= off_d;
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid); // R8
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> !out_valid); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> ($stable(best_len) && $stable(best_off))); // R9
endmodule

// File: tb/sim_match_len_cmp.sv
module sim_match_len_cmp;
  localparam int VEC     = 4;
  localparam int MAX_OFF = 262144;
  localparam int LENW    = $clog2(VEC + 1);
  localparam int OFFW    = $clog2(MAX_OFF + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [VEC*VEC*8-1:0]     cur_win;
  logic [VEC*VEC*VEC*8-1:0] cand_data;
  logic [VEC*VEC-1:0]       cand_ok;
  logic [VEC*VEC*OFFW-1:0]  cand_off;
  logic                     out_valid;
  logic [VEC*LENW-1:0]      best_len;
  logic [VEC*OFFW-1:0]      best_off;

  always #10 clk = ~clk;

  match_len_cmp #(.VEC(VEC), .MAX_OFF(MAX_OFF)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_win(cur_win),
    .cand_data(cand_data), .cand_ok(cand_ok), .cand_off(cand_off),
    .out_valid(out_valid), .best_len(best_len), .best_off(best_off)
  );

  logic [7:0]  cb [VEC][VEC];
  logic [7:0]  kb [VEC][VEC][VEC];
  logic        okb[VEC][VEC];
  int          ofb[VEC][VEC];
  int          exp_len[VEC];
  int          exp_off[VEC];
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  task automatic chk(input bit cond, input string req, input int act, input int expv);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic pack();
    for (int p = 0; p < VEC; p++)
      for (int b = 0; b < VEC; b++) begin
        cur_win[(p*VEC+b)*8 +: 8] = cb[p][b];
        for (int c = 0; c < VEC; c++)
          cand_data[((p*VEC+c)*VEC+b)*8 +: 8] = kb[p][c][b];
      end
    for (int p = 0; p < VEC; p++)
      for (int c = 0; c < VEC; c++) begin
        cand_ok[p*VEC+c] = okb[p][c];
        cand_off[(p*VEC+c)*OFFW +: OFFW] = OFFW'(ofb[p][c]);
      end
  endtask

  task automatic model();
    for (int p = 0; p < VEC; p++) begin
      exp_len[p] = 0;
      exp_off[p] = 0;
      for (int c = 0; c < VEC; c++) begin
        int l;
        l = 0;
        while (l < VEC && kb[p][c][l] == cb[p][l]) l++;
        if (!okb[p][c] || ofb[p][c] == 0 || ofb[p][c] > MAX_OFF) l = 0;
        if (l > exp_len[p]) begin
          exp_len[p] = l;
          exp_off[p] = ofb[p][c];
        end
      end
    end
  endtask

  task automatic compare(input string req);
    for (int p = 0; p < VEC; p++) begin
      chk(int'(best_len[p*LENW +: LENW]) == exp_len[p], {req, " len"},
          int'(best_len[p*LENW +: LENW]), exp_len[p]);
      chk(int'(best_off[p*OFFW +: OFFW]) == exp_off[p], {req, " off"},
          int'(best_off[p*OFFW +: OFFW]), exp_off[p]);
    end
  endtask

  task automatic apply(input string req);
    @(negedge clk);
    pack();
    in_valid = 1'b1;
    model();
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R8 valid", int'(out_valid), 1);
    compare(req);
  endtask

  task automatic fill_base(input int seed);
    for (int p = 0; p < VEC; p++)
      for (int c = 0; c < VEC; c++) begin
        okb[p][c] = 1'b1;
        ofb[p][c] = 100 + p*VEC + c;
        for (int b = 0; b < VEC; b++) begin
          cb[p][b]    = 8'(seed*13 + p*5 + b + 65);
          kb[p][c][b] = 8'(seed*13 + p*5 + b + 65) ^ 8'h80;
        end
      end
  endtask

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    cur_win = '0; cand_data = '0; cand_ok = '0; cand_off = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(out_valid === 1'b0, "R10 valid", int'(out_valid), 0);
    chk(best_len === '0, "R10 len", int'(best_len), 0);
    chk(best_off === '0, "R10 off", int'(best_off), 0);

    // R1 R2 word example: "text" vs tan_/text/texl/teen
    fill_base(1);
    cb[0][0]="t"; cb[0][1]="e"; cb[0][2]="x"; cb[0][3]="t";
    kb[0][0][0]="t"; kb[0][0][1]="a"; kb[0][0][2]="n"; kb[0][0][3]="_";
    kb[0][1][0]="t"; kb[0][1][1]="e"; kb[0][1][2]="x"; kb[0][1][3]="t";
    kb[0][2][0]="t"; kb[0][2][1]="e"; kb[0][2][2]="x"; kb[0][2][3]="l";
    kb[0][3][0]="t"; kb[0][3][1]="e"; kb[0][3][2]="e"; kb[0][3][3]="n";
    apply("R1 R2 example");
    chk(int'(best_len[0 +: LENW]) == 4, "R2 full match", int'(best_len[0 +: LENW]), 4);

    // R3 tie: banks 1,2,3 all length 2, bank 1 must win
    fill_base(2);
    for (int c = 1; c < VEC; c++) begin
      kb[2][c][0] = cb[2][0];
      kb[2][c][1] = cb[2][1];
    end
    apply("R3 tie");
    chk(int'(best_off[2*OFFW +: OFFW]) == ofb[2][1], "R3 lowest bank",
        int'(best_off[2*OFFW +: OFFW]), ofb[2][1]);

    // R7 all candidates unusable although bytes match fully
    fill_base(3);
    for (int c = 0; c < VEC; c++) begin
      for (int b = 0; b < VEC; b++) kb[1][c][b] = cb[1][b];
      okb[1][c] = (c != 0);
      ofb[1][c] = (c == 1) ? 0 : MAX_OFF + 1;
    end
    apply("R4 R5 R6 R7 gated");
    chk(best_off[1*OFFW +: OFFW] == '0, "R7 zero off", int'(best_off[1*OFFW +: OFFW]), 0);

    // R9 hold: change inputs with in_valid low
    fill_base(4);
    for (int b = 0; b < VEC; b++) kb[0][0][b] = cb[0][b];
    apply("R9 setup");
    fill_base(5);
    @(negedge clk);
    pack();
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 drop", int'(out_valid), 0);
    compare("R9 hold");

    // R1 R2 R4 R5 R6 R11 sweep of mismatch index per bank, 5^VEC combos
    for (int t = 0; t < 625; t++) begin
      for (int p = 0; p < VEC; p++) begin
        for (int b = 0; b < VEC; b++) cb[p][b] = 8'(t*13 + p*5 + b*3 + 65);
        for (int c = 0; c < VEC; c++) begin
          int k, sel, d;
          d = 1;
          for (int i = 0; i < c; i++) d = d * 5;
          k = ((t / d) + p) % 5;
          for (int b = 0; b < VEC; b++)
            kb[p][c][b] = (b == k) ? (cb[p][b] ^ 8'h20) : cb[p][b];
          sel = (t*7 + p*3 + c) % 6;
          case (sel)
            0: ofb[p][c] = 0;
            1: ofb[p][c] = 1;
            2: ofb[p][c] = 2047;
            3: ofb[p][c] = MAX_OFF;
            4: ofb[p][c] = MAX_OFF + 1;
            default: ofb[p][c] = 3 + c + 4*p;
          endcase
          okb[p][c] = ((t + c + p) % 7) != 0;
        end
      end
      apply("R1 R2 R11 sweep");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule